// File: doc/BRIEF.md
# Interlaced Raster Sync Generator

This block produces the horizontal and vertical timing of a 4:2:2 digital video stream for 525-line and 625-line interlaced rasters. A horizontal counter and a line counter advance once per clock enable. Horizontal sync, vertical sync, the field flag and the active-video window are decoded from those two counters. Two one-clock marks show where the start-of-active and end-of-active reference codes belong when embedded sync is wanted.

The block runs in one of two clock modes. In double-rate mode, one enable advances one timing unit, and a line has 858, 864, 780 or 944 units depending on the standard. In single-rate mode, each enable covers two units, so a line has half as many clocks. All horizontal positions are given in units, with u = h in double-rate mode and u = 2h in single-rate mode. A small byte-wide register port moves the active-video edges and the vertical sync start line. Each value becomes effective only when its upper part is written.

Top module: `raster_sync_gen`

## Requirements
- R1: While reset is held and just after it, h_pos = 0, line_num = 1, fid = 0, hs = 1, vs = 0, avid = 0, and sav_mark and eav_mark are both 0.
- R2: std_sel selects the line length in units: 0 gives 858, 1 gives 864, 2 gives 780 and 3 gives 944. h_pos counts from 0 to (length − 1) in double-rate mode (single_clk = 0) and from 0 to (length/2 − 1) in single-rate mode, then returns to 0.
- R3: line_num counts from 1 to the frame total and then returns to 1. It advances when h_pos wraps. The frame total is LINES_A (525 by default) for std_sel 0 and 2, and LINES_B (625 by default) for std_sel 1 and 3.
- R4: hs is 1 exactly when u < 128. This gives 128 clocks in double-rate mode and 64 clocks in single-rate mode.
- R5: In double-rate mode, avid is 1 exactly for start ≤ u < stop. The window wraps past the line end when start > stop. Until a value is written, start and stop take per-standard defaults: 85/805, 88/808, 86/726 and 872/696 for std_sel 0 to 3.
- R6: In single-rate mode, the window opens 4 units (2 clocks) before start and still closes at stop. With the NTSC defaults, avid is 1 from h = 41 to h = 402.
- R7: Writes with wr_en = 1 use these addresses: 0 and 1 for start (low byte, then bits [9:8]), 2 and 3 for stop, and 4 and 5 for the vertical sync line. A low-byte write alone changes nothing visible. A high write with wr_data[7:2] = 0 commits {wr_data[1:0], stored low byte}. A high write with any of bits [7:2] set is ignored. A committed value persists across standard and mode changes.
- R8: In field 1, vs rises on line V at the first clock with u ≥ 64. It falls on line V+3 at the same position. V defaults to 4 for 525-line standards and 1 for 625-line standards.
- R9: In field 2, vs rises on line V + (L−1)/2 at the first clock with u ≥ G/2 + 64, where L is the frame total and G is the line length in units. It falls three lines later at the same position.
- R10: fid is 0 on lines 1 to (L+1)/2 and 1 from line (L+3)/2 to L. For L = 525, the first line with fid = 1 is line 264.
- R11: With embed_en = 1, sav_mark is 1 for the single clock on which avid opens, and eav_mark is 1 for the first clock after avid closes. With embed_en = 0, both marks stay 0.
- R12: The counters hold while ce = 0. A change of std_sel or single_clk restarts the counters at h_pos = 0, line_num = 1 on the next clock that has ce = 1, including a change made while ce was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Clock enable; one timing step per enabled clock |
| single_clk | input | 1 | 1 = single-rate mode (two units per clock) |
| std_sel | input | 2 | Raster standard select |
| embed_en | input | 1 | Enables the reference-code marks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| hs | output | 1 | Horizontal sync |
| vs | output | 1 | Vertical sync |
| fid | output | 1 | Field flag, 1 in the second field |
| avid | output | 1 | Active video window |
| sav_mark | output | 1 | Start-of-active code position |
| eav_mark | output | 1 | End-of-active code position |
| h_pos | output | 11 | Horizontal counter in clocks |
| line_num | output | 10 | Line number, starting at 1 |

## Verification
The bench uses short frames of 21 and 25 lines, so that complete fields pass quickly. The active window is probed one clock on each side of each edge in double-rate NTSC, in single-rate NTSC and in double-rate PAL. These three cases separate the two-clock early opening from a plain halving of positions, and separate the line lengths of the two standards. The register checks use a low-only write, a high write with reserved bits set, and then valid commits; a decode that commits on the wrong byte fails one of these. Vertical sync is probed in both fields to show the half-line offset, and the restart on a standard or mode change is tried both with the enable high and with the change made while the enable is low.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam int UW = 11;     // horizontal position / counter width
    localparam int LW = 10;     // line number width
    localparam int RW = 10;     // programmable value width

    typedef enum logic [1:0] {
        STD_N601 = 2'd0,
        STD_P601 = 2'd1,
        STD_NSQ  = 2'd2,
        STD_PSQ  = 2'd3
    } std_e;

    typedef struct packed {
        logic [UW-1:0] h;
        logic [LW-1:0] ln;
        logic [2:0]    cfg;
        logic          pend;
    } cnt_st_t;

    typedef struct packed {
        logic [7:0]    start_lo;
        logic [7:0]    stop_lo;
        logic [7:0]    vsl_lo;
        logic [RW-1:0] start_v;
        logic [RW-1:0] stop_v;
        logic [RW-1:0] vsl_v;
        logic          start_p;
        logic          stop_p;
        logic          vsl_p;
    } reg_st_t;

    function automatic logic [RW-1:0] dflt_start(input logic [1:0] s);
        case (std_e'(s))
            STD_N601: return RW'(85);
            STD_P601: return RW'(88);
            STD_NSQ:  return RW'(86);
            default:  return RW'(872);
        endcase
    endfunction

    function automatic logic [RW-1:0] dflt_stop(input logic [1:0] s);
        case (std_e'(s))
            STD_N601: return RW'(805);
            STD_P601: return RW'(808);
            STD_NSQ:  return RW'(726);
            default:  return RW'(696);
        endcase
    endfunction

    function automatic logic [RW-1:0] dflt_vsl(input logic [1:0] s);
        return s[0] ? RW'(1) : RW'(4);
    endfunction

endpackage

// File: rtl/rsg_count.sv
module rsg_count
    import rsg_pkg::*;
#(
    parameter int H_N601  = 858,
    parameter int H_P601  = 864,
    parameter int H_NSQ   = 780,
    parameter int H_PSQ   = 944,
    parameter int LINES_A = 525,
    parameter int LINES_B = 625
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          single_clk,
    input  logic [1:0]    std_sel,
    output logic [UW-1:0] h,
    output logic [LW-1:0] ln,
    output logic [UW-1:0] grid,
    output logic [LW-1:0] ltot
);

    localparam int LMAX = (LINES_A > LINES_B) ? LINES_A : LINES_B;

    cnt_st_t       s_q, s_d;
    logic [UW-1:0] htot_clk;
    logic [2:0]    cfg;
    logic          chg;
    logic          restart;

    always_comb begin
        case (std_e'(std_sel))
            STD_N601: grid = UW'(H_N601);
            STD_P601: grid = UW'(H_P601);
            STD_NSQ:  grid = UW'(H_NSQ);
            default:  grid = UW'(H_PSQ);
        endcase
        htot_clk = single_clk ? (grid >> 1) : grid;
        ltot     = std_sel[0] ? LW'(LINES_B) : LW'(LINES_A);
        cfg      = {single_clk, std_sel};
        chg      = (cfg != s_q.cfg);
        restart  = s_q.pend | chg;

        s_d     = s_q;
        s_d.cfg = cfg;
        if (ce) begin
            if (restart) begin
                s_d.h    = '0;
                s_d.ln   = LW'(1);
                s_d.pend = 1'b0;
            end else if (s_q.h == htot_clk - UW'(1)) begin
                s_d.h  = '0;
                s_d.ln = (s_q.ln == ltot) ? LW'(1) : s_q.ln + LW'(1);
            end else begin
                s_d.h = s_q.h + UW'(1);
            end
        end else if (chg) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.h    <= '0;
            s_q.ln   <= LW'(1);
            s_q.cfg  <= cfg;
            s_q.pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign h  = s_q.h;
    assign ln = s_q.ln;

    // R2
    hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !restart && s_q.h == htot_clk - UW'(1)) |=> (s_q.h == '0));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ln >= LW'(1)) && (s_q.ln <= LW'(LMAX)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(s_q.h) && $stable(s_q.ln)));

endmodule

// File: rtl/rsg_regs.sv
module rsg_regs
    import rsg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [1:0]    std_sel,
    output logic [RW-1:0] start_pos,
    output logic [RW-1:0] stop_pos,
    output logic [RW-1:0] vs_line
);

    reg_st_t s_q, s_d;
    logic    hi_ok;

    always_comb begin
        hi_ok = (wr_data[7:2] == 6'd0);
        s_d   = s_q;
        if (wr_en) begin
            case (wr_addr)
                3'd0: s_d.start_lo = wr_data;
                3'd1: if (hi_ok) begin
                          s_d.start_v = {wr_data[1:0], s_q.start_lo};
                          s_d.start_p = 1'b1;
                      end
                3'd2: s_d.stop_lo = wr_data;
                3'd3: if (hi_ok) begin
                          s_d.stop_v = {wr_data[1:0], s_q.stop_lo};
                          s_d.stop_p = 1'b1;
                      end
                3'd4: s_d.vsl_lo = wr_data;
                3'd5: if (hi_ok) begin
                          s_d.vsl_v = {wr_data[1:0], s_q.vsl_lo};
                          s_d.vsl_p = 1'b1;
                      end
                default: ;
            endcase
        end
        start_pos = s_q.start_p ? s_q.start_v : dflt_start(std_sel);
        stop_pos  = s_q.stop_p  ? s_q.stop_v  : dflt_stop(std_sel);
        vs_line   = s_q.vsl_p   ? s_q.vsl_v   : dflt_vsl(std_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7
    lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[0]) |=> ($stable(s_q.start_v) && $stable(s_q.stop_v) &&
                                    $stable(s_q.vsl_v) && $stable(s_q.start_p) &&
                                    $stable(s_q.stop_p) && $stable(s_q.vsl_p)));

    // R7
    reserved_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd3 && wr_data[7:2] != 6'd0) |=> $stable(s_q.stop_v));

endmodule

// File: rtl/rsg_decode.sv
module rsg_decode
    import rsg_pkg::*;
#(
    parameter int HS_W    = 128,
    parameter int VS_SPAN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single_clk,
    input  logic          embed_en,
    input  logic [UW-1:0] h,
    input  logic [LW-1:0] ln,
    input  logic [UW-1:0] grid,
    input  logic [LW-1:0] ltot,
    input  logic [RW-1:0] start_pos,
    input  logic [RW-1:0] stop_pos,
    input  logic [RW-1:0] vs_line,
    output logic          hs,
    output logic          vs,
    output logic          fid,
    output logic          avid,
    output logic          sav_mark,
    output logic          eav_mark
);

    localparam int EARLY = 4;   // two single-rate clocks, in units

    logic [UW-1:0] u;
    logic [UW-1:0] st_w, sp_w, es;
    logic [UW-1:0] sav_h, eav_h;
    logic [UW-1:0] p1, p2;
    logic [LW-1:0] l1, l2, half, f2;

    function automatic logic in_win(input logic [UW-1:0] x, input logic [UW-1:0] a,
                                    input logic [UW-1:0] b);
        if (a <= b) return (x >= a) && (x < b);
        return (x >= a) || (x < b);
    endfunction

    function automatic logic at_or_after(input logic [LW-1:0] l, input logic [UW-1:0] x,
                                         input logic [LW-1:0] tl, input logic [UW-1:0] tx);
        return (l > tl) || ((l == tl) && (x >= tx));
    endfunction

    always_comb begin
        u    = single_clk ? {h[UW-2:0], 1'b0} : h;
        st_w = {{(UW-RW){1'b0}}, start_pos};
        sp_w = {{(UW-RW){1'b0}}, stop_pos};
        if (!single_clk)            es = st_w;
        else if (st_w >= UW'(EARLY)) es = st_w - UW'(EARLY);
        else                        es = st_w + grid - UW'(EARLY);

        avid = in_win(u, es, sp_w);
        hs   = (u < UW'(HS_W));

        sav_h    = single_clk ? ((es + UW'(1)) >> 1) : es;
        eav_h    = single_clk ? ((sp_w + UW'(1)) >> 1) : sp_w;
        sav_mark = embed_en && (h == sav_h);
        eav_mark = embed_en && (h == eav_h);

        half = (ltot - LW'(1)) >> 1;
        f2   = (ltot + LW'(3)) >> 1;
        fid  = (ln >= f2);

        l1 = vs_line;
        l2 = vs_line + half;
        p1 = UW'(HS_W / 2);
        p2 = (grid >> 1) + UW'(HS_W / 2);
        vs = (at_or_after(ln, u, l1, p1) && !at_or_after(ln, u, l1 + LW'(VS_SPAN), p1)) ||
             (at_or_after(ln, u, l2, p2) && !at_or_after(ln, u, l2 + LW'(VS_SPAN), p2));
    end

    // R11
    sav_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sav_mark |-> avid);

    // R11
    eav_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eav_mark |-> !avid);

    // R10
    fid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fid) |-> (ln == f2));

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
    import rsg_pkg::*;
#(
    parameter int H_N601  = 858,
    parameter int H_P601  = 864,
    parameter int H_NSQ   = 780,
    parameter int H_PSQ   = 944,
    parameter int LINES_A = 525,
    parameter int LINES_B = 625,
    parameter int HS_W    = 128,
    parameter int VS_SPAN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce,
    input  logic        single_clk,
    input  logic [1:0]  std_sel,
    input  logic        embed_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        hs,
    output logic        vs,
    output logic        fid,
    output logic        avid,
    output logic        sav_mark,
    output logic        eav_mark,
    output logic [10:0] h_pos,
    output logic [9:0]  line_num
);

    logic [UW-1:0] h, grid;
    logic [LW-1:0] ln, ltot;
    logic [RW-1:0] start_pos, stop_pos, vs_line;

    rsg_count #(
        .H_N601 (H_N601),  .H_P601 (H_P601),
        .H_NSQ  (H_NSQ),   .H_PSQ  (H_PSQ),
        .LINES_A(LINES_A), .LINES_B(LINES_B)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .single_clk(single_clk),
        .std_sel   (std_sel),
        .h         (h),
        .ln        (ln),
        .grid      (grid),
        .ltot      (ltot)
    );

    rsg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .std_sel  (std_sel),
        .start_pos(start_pos),
        .stop_pos (stop_pos),
        .vs_line  (vs_line)
    );

    rsg_decode #(
        .HS_W   (HS_W),
        .VS_SPAN(VS_SPAN)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .single_clk(single_clk),
        .embed_en  (embed_en),
        .h         (h),
        .ln        (ln),
        .grid      (grid),
        .ltot      (ltot),
        .start_pos (start_pos),
        .stop_pos  (stop_pos),
        .vs_line   (vs_line),
        .hs        (hs),
        .vs        (vs),
        .fid       (fid),
        .avid      (avid),
        .sav_mark  (sav_mark),
        .eav_mark  (eav_mark)
    );

    assign h_pos    = h;
    assign line_num = ln;

endmodule

// File: tb/sim_raster_sync_gen.sv
`timescale 1ns/1ps
module sim_raster_sync_gen;

    localparam int LA = 21;
    localparam int LB = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic        single_clk = 1'b0;
    logic [1:0]  std_sel = 2'd0;
    logic        embed_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        hs, vs, fid, avid, sav_mark, eav_mark;
    logic [10:0] h_pos;
    logic [9:0]  line_num;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    raster_sync_gen #(.LINES_A(LA), .LINES_B(LB)) u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .single_clk(single_clk),
        .std_sel(std_sel), .embed_en(embed_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .hs(hs), .vs(vs), .fid(fid),
        .avid(avid), .sav_mark(sav_mark), .eav_mark(eav_mark),
        .h_pos(h_pos), .line_num(line_num)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at line %0d h %0d: got %0d expected %0d",
                     req, line_num, h_pos, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic go(input int l, input int h);
        int n = 0;
        while (!(line_num == 10'(l) && h_pos == 11'(h))) begin
            @(negedge clk);
            n++;
            if (n > 60000) begin
                check("goto", 0, 1);
                return;
            end
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 h", h_pos, 0);
        check("R1 line", line_num, 1);
        check("R1 fid", fid, 0);
        check("R1 hs", hs, 1);
        check("R1 vs", vs, 0);
        check("R1 avid", avid, 0);
        check("R1 marks", {sav_mark, eav_mark}, 0);
    endtask

    task automatic t_ntsc_double();
        go(1, 857); step();
        check("R2 wrap h", h_pos, 0);
        check("R3 line step", line_num, 2);
        go(2, 127); check("R4 hs end-1", hs, 1);
        step();     check("R4 hs end", hs, 0);
        go(3, 84);  check("R5 avid before", avid, 0); check("R11 sav before", sav_mark, 0);
        step();     check("R5 avid open", avid, 1);   check("R11 sav", sav_mark, 1);
        step();     check("R11 sav one clock", sav_mark, 0);
        go(3, 804); check("R5 avid last", avid, 1);   check("R11 eav early", eav_mark, 0);
        step();     check("R5 avid close", avid, 0);  check("R11 eav", eav_mark, 1);
        step();     check("R11 eav one clock", eav_mark, 0);
        go(4, 63);  check("R8 vs before", vs, 0);
        step();     check("R8 vs rise", vs, 1);
        go(7, 63);  check("R8 vs hold", vs, 1);
        step();     check("R8 vs fall", vs, 0);
        go(11, 857); check("R10 fid field1", fid, 0);
        step();      check("R10 fid field2", fid, 1);
        go(14, 492); check("R9 vs before", vs, 0);
        step();      check("R9 vs rise", vs, 1);
        go(17, 492); check("R9 vs hold", vs, 1);
        step();      check("R9 vs fall", vs, 0);
        go(LA, 857); step();
        check("R3 frame wrap line", line_num, 1);
        check("R3 frame wrap h", h_pos, 0);
        check("R10 fid back", fid, 0);
    endtask

    task automatic t_ntsc_single();
        single_clk = 1'b1; step();
        check("R12 restart h", h_pos, 0);
        check("R12 restart line", line_num, 1);
        go(1, 40);  check("R6 avid early-1", avid, 0);
        step();     check("R6 avid open", avid, 1); check("R11 sav single", sav_mark, 1);
        go(1, 63);  check("R4 hs single", hs, 1);
        step();     check("R4 hs single end", hs, 0);
        go(1, 402); check("R6 avid last", avid, 1);
        step();     check("R6 avid close", avid, 0); check("R11 eav single", eav_mark, 1);
        go(1, 428); step();
        check("R2 single wrap h", h_pos, 0);
        check("R3 single line", line_num, 2);
    endtask

    task automatic t_pal_regs();
        single_clk = 1'b0; std_sel = 2'd1; step();
        check("R12 std restart h", h_pos, 0);
        check("R12 std restart line", line_num, 1);
        go(1, 63);  check("R8 pal vs before", vs, 0);
        step();     check("R8 pal vs rise", vs, 1);
        go(1, 863); step();
        check("R2 pal wrap h", h_pos, 0);
        check("R3 pal line", line_num, 2);
        go(2, 87);  check("R5 pal avid before", avid, 0);
        step();     check("R5 pal avid open", avid, 1);
        wr(3'd0, 8'd20);
        go(3, 87);  check("R7 low only before", avid, 0);
        step();     check("R7 low only default", avid, 1);
        wr(3'd1, 8'h00);
        go(4, 19);  check("R7 start before", avid, 0);
        step();     check("R7 start open", avid, 1); check("R11 sav prog", sav_mark, 1);
        wr(3'd2, 8'h2C);
        wr(3'd3, 8'h06);
        go(5, 807); check("R7 reserved ignored", avid, 1);
        step();     check("R7 reserved default stop", avid, 0);
        wr(3'd3, 8'h02);
        go(6, 555); check("R7 stop last", avid, 1);
        step();     check("R7 stop close", avid, 0); check("R11 eav prog", eav_mark, 1);
    endtask

    task automatic t_hold();
        int hk;
        int lk;
        ce = 1'b0; hk = int'(h_pos); lk = int'(line_num);
        repeat (5) step();
        check("R12 hold h", h_pos, hk);
        check("R12 hold line", line_num, lk);
        std_sel = 2'd0;
        repeat (2) step();
        check("R12 pending hold", h_pos, hk);
        ce = 1'b1; step();
        check("R12 pending restart h", h_pos, 0);
        check("R12 pending restart line", line_num, 1);
    endtask

    task automatic t_embed_off();
        embed_en = 1'b0;
        go(1, 19); check("R7 persist before", avid, 0);
        step();    check("R7 persist open", avid, 1); check("R11 sav off", sav_mark, 0);
        go(1, 556); check("R7 persist close", avid, 0); check("R11 eav off", eav_mark, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ntsc_double();
        t_ntsc_single();
        t_pal_regs();
        t_hold();
        t_embed_off();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule